// File: doc/BRIEF.md
# Scan Shift Weighted Transition Meter

This block watches the serial bit stream entering or leaving one scan chain of `CHAIN_LEN` cells. For every vector it estimates shift power as a weighted transition count. Each pair of neighbouring bits that differ adds a weight equal to the number of cells that the resulting toggle ripples through while the vector is shifted. In load direction, a toggle between bits j and j+1 crosses the cells still ahead of it, so it weighs `CHAIN_LEN - j`. In unload direction the chain empties from the opposite end, so it weighs `j`.

Bits arrive one per cycle with `bit_vld` high, bit 1 first. A `vec_start` strobe can mark bit 1. After bit `CHAIN_LEN` the total appears on `wtc` together with a one-cycle `done` pulse. At the same moment `over_limit` reports whether the total is above a programmable `limit`. The meter then re-arms for the next vector by itself.

Top module: `scan_wtc_meter`

## Requirements
- R1: After reset, `done`, `over_limit` and `wtc` are all 0.
- R2: The first bit of a vector only seeds the previous-bit register and adds nothing. A `vec_start`-qualified valid bit always becomes bit 1 and discards any partial vector.
- R3: With `dir_sel` = 0 (load direction), each j in 1..CHAIN_LEN-1 whose bits j and j+1 differ adds CHAIN_LEN-j to the total.
- R4: With `dir_sel` = 1 (unload direction), each j in 1..CHAIN_LEN-1 whose bits j and j+1 differ adds j to the total.
- R5: `done` is high for exactly one cycle, in the cycle after the edge that accepts bit CHAIN_LEN. `wtc` keeps its value until the next `done`.
- R6: Cycles with `bit_vld` low change nothing, whatever `bit_in`, `vec_start` and `dir_sel` carry.
- R7: `over_limit` is high only together with `done`, and only when the total is strictly greater than `limit`. A total equal to `limit` gives 0.
- R8: The worst case CHAIN_LEN*(CHAIN_LEN-1)/2, reached by an alternating vector in either direction, is reported exactly.
- R9: After bit CHAIN_LEN, the next valid bit starts a new vector without `vec_start`. The direction is sampled only with bit 1 of each vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | `bit_in` carries a scan bit this cycle |
| bit_in | input | 1 | Serial scan bit |
| vec_start | input | 1 | Marks the valid bit as bit 1 of a vector |
| dir_sel | input | 1 | 0 = load direction, 1 = unload direction (sampled at bit 1) |
| limit | input | CNT_W | Threshold for `over_limit` |
| done | output | 1 | One-cycle strobe: `wtc` holds a new total |
| wtc | output | CNT_W | Weighted transition count of the last vector |
| over_limit | output | 1 | Total exceeded `limit`; valid with `done` |

## Verification
Direction is latched only on bit 1. A wrong weight caused by sampling it on every bit therefore stays hidden unless `dir_sel` changes part-way through a vector. The back-to-back test flips `dir_sel` on every bit after the first. It sends no `vec_start`, so it also shows that the meter re-arms after bit CHAIN_LEN. Abandoning a partial vector is reached by sending a few bits and then raising `vec_start`. Idle cycles carry random `bit_in`, `vec_start` and `dir_sel` values to show they are ignored.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic {
      SHIFT_LOAD   = 1'b0,
      SHIFT_UNLOAD = 1'b1
   } shift_dir_e;
endpackage

// File: rtl/wtc_weight.sv
// Weight of a toggle between bit j and bit j+1 for the latched shift direction.
module wtc_weight
   import wtc_pkg::*;
#(
   parameter int CHAIN_LEN = 16,
   parameter int POS_W     = 5,
   parameter int CNT_W     = 7
) (
   input  logic [POS_W-1:0] j_idx,
   input  shift_dir_e       dir,
   output logic [CNT_W-1:0] weight
);
   always_comb begin
      if (dir == SHIFT_UNLOAD)
         weight = CNT_W'(j_idx);
      else
         weight = CNT_W'(CHAIN_LEN) - CNT_W'(j_idx);
   end
endmodule

// File: rtl/wtc_pos_ctr.sv
// Tracks the position inside the vector; cnt equals the bits already taken.
module wtc_pos_ctr #(
   parameter int CHAIN_LEN = 16,
   parameter int POS_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             vec_start,
   output logic             first,
   output logic             last,
   output logic [POS_W-1:0] j_idx
);
   localparam logic [POS_W-1:0] LAST_CNT = POS_W'(CHAIN_LEN - 1);

   logic [POS_W-1:0] cnt;

   assign first = vec_start || (cnt == '0);
   assign last  = !first && (cnt == LAST_CNT);
   assign j_idx = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (accept) begin
         if (first)
            cnt <= POS_W'(1);
         else if (last)
            cnt <= '0;
         else
            cnt <= cnt + POS_W'(1);
      end
   end
endmodule

// File: rtl/wtc_accum.sv
// Accumulates weights, holds the previous bit and the latched direction.
module wtc_accum
   import wtc_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             first,
   input  logic             last,
   input  logic             bit_in,
   input  logic             dir_in,
   input  logic [CNT_W-1:0] limit,
   input  logic [CNT_W-1:0] weight,
   output shift_dir_e       dir_q,
   output logic             done,
   output logic [CNT_W-1:0] wtc,
   output logic             over_limit
);
   logic             prev_bit;
   logic [CNT_W-1:0] acc;
   logic [CNT_W-1:0] add;
   logic [CNT_W-1:0] total;

   assign add   = (prev_bit ^ bit_in) ? weight : '0;
   assign total = acc + add;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_bit   <= 1'b0;
         acc        <= '0;
         dir_q      <= SHIFT_LOAD;
         done       <= 1'b0;
         wtc        <= '0;
         over_limit <= 1'b0;
      end else begin
         done       <= 1'b0;
         over_limit <= 1'b0;
         if (accept) begin
            prev_bit <= bit_in;
            if (first) begin
               acc   <= '0;
               dir_q <= shift_dir_e'(dir_in);
            end else begin
               acc <= total;
               if (last) begin
                  done       <= 1'b1;
                  wtc        <= total;
                  over_limit <= (total > limit);
               end
            end
         end
      end
   end
endmodule

// File: rtl/scan_wtc_meter.sv
module scan_wtc_meter
   import wtc_pkg::*;
#(
   parameter int CHAIN_LEN = 16,
   parameter int MAX_WTC   = CHAIN_LEN * (CHAIN_LEN - 1) / 2,
   parameter int SUM_W     = $clog2(MAX_WTC + 1),
   parameter int POS_W     = $clog2(CHAIN_LEN + 1),
   parameter int CNT_W     = (SUM_W > POS_W) ? SUM_W : POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             vec_start,
   input  logic             dir_sel,
   input  logic [CNT_W-1:0] limit,
   output logic             done,
   output logic [CNT_W-1:0] wtc,
   output logic             over_limit
);
   generate
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("scan_wtc_meter: CHAIN_LEN must be at least 2");
      end
      if (MAX_WTC != CHAIN_LEN * (CHAIN_LEN - 1) / 2) begin : g_bad_max
         $error("scan_wtc_meter: MAX_WTC must not be overridden");
      end
   endgenerate

   logic             first;
   logic             last;
   logic [POS_W-1:0] j_idx;
   logic [CNT_W-1:0] weight;
   shift_dir_e       dir_q;

   wtc_pos_ctr #(.CHAIN_LEN(CHAIN_LEN), .POS_W(POS_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .accept(bit_vld), .vec_start(vec_start),
      .first(first), .last(last), .j_idx(j_idx)
   );

   wtc_weight #(.CHAIN_LEN(CHAIN_LEN), .POS_W(POS_W), .CNT_W(CNT_W)) u_wt (
      .j_idx(j_idx), .dir(dir_q), .weight(weight)
   );

   wtc_accum #(.CNT_W(CNT_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .accept(bit_vld), .first(first), .last(last),
      .bit_in(bit_in), .dir_in(dir_sel), .limit(limit), .weight(weight),
      .dir_q(dir_q), .done(done), .wtc(wtc), .over_limit(over_limit)
   );
endmodule

// File: rtl/scan_wtc_meter_chk.sv
module scan_wtc_meter_chk #(
   parameter int CHAIN_LEN = 16,
   parameter int CNT_W     = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_vld,
   input logic [CNT_W-1:0] limit,
   input logic             done,
   input logic [CNT_W-1:0] wtc,
   input logic             over_limit
);
   localparam int MAX_WTC = CHAIN_LEN * (CHAIN_LEN - 1) / 2;

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bit_vld));

   // R5
   wtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || $stable(wtc)));

   // R7
   over_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !over_limit);

   // R7
   over_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (over_limit == (wtc > $past(limit))));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(wtc) <= MAX_WTC));
endmodule

bind scan_wtc_meter scan_wtc_meter_chk #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_wtc_chk (
   .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .limit(limit),
   .done(done), .wtc(wtc), .over_limit(over_limit)
);

// File: tb/scan_wtc_meter_bench.sv
module scan_wtc_meter_bench;
   localparam int M     = 16;
   localparam int CNT_W = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bit_vld = 1'b0;
   logic             bit_in = 1'b0;
   logic             vec_start = 1'b0;
   logic             dir_sel = 1'b0;
   logic [CNT_W-1:0] limit = '0;
   logic             done;
   logic [CNT_W-1:0] wtc;
   logic             over_limit;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   scan_wtc_meter #(.CHAIN_LEN(M)) u_scan_wtc_meter (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .vec_start(vec_start), .dir_sel(dir_sel), .limit(limit),
      .done(done), .wtc(wtc), .over_limit(over_limit)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bit position p (1..M) is v[p-1]
   function automatic int ref_wtc(input logic [M-1:0] v, input bit unload);
      int s = 0;
      for (int j = 1; j < M; j++)
         if (v[j-1] != v[j]) s += unload ? j : (M - j);
      return s;
   endfunction

   // Sends one vector; checks done timing, total and over flag.
   task automatic push_vec(input logic [M-1:0] v, input bit unload, input int gap,
                           input bit use_start, input bit flip_dir, input int lim,
                           input string req);
      bit early = 0;
      int exp_w;
      exp_w = ref_wtc(v, unload);
      for (int i = 0; i < M; i++) begin
         @(negedge clk);
         bit_vld   = 1'b1;
         bit_in    = v[i];
         vec_start = use_start && (i == 0);
         dir_sel   = (flip_dir && i > 0) ? ~unload : unload;
         limit     = CNT_W'(lim);
         @(posedge clk);
         #2;
         if (i < M - 1) begin
            if (done) early = 1;
            if (gap > 0) begin
               @(negedge clk);
               bit_vld = 1'b0;
               for (int g = 0; g < gap; g++) begin
                  bit_in    = 1'($urandom);
                  vec_start = 1'($urandom);
                  dir_sel   = 1'($urandom);
                  @(negedge clk);
               end
            end
         end
      end
      check(!early, {req, " R5 no early done"}, early, 0);
      check(done == 1'b1, {req, " R5 done after last bit"}, done, 1);
      check(int'(wtc) == exp_w, {req, " total"}, wtc, exp_w);
      check(over_limit == (exp_w > lim), {req, " R7 over_limit"}, over_limit, exp_w > lim);
   endtask

   task automatic idle_check(input string req);
      int held;
      held = wtc;
      @(negedge clk);
      bit_vld = 1'b0; vec_start = 1'b0;
      @(posedge clk);
      #2;
      check(done == 1'b0, {req, " R5 done single cycle"}, done, 0);
      check(int'(wtc) == held, {req, " R5 wtc held"}, wtc, held);
      check(over_limit == 1'b0, {req, " R7 over cleared"}, over_limit, 0);
   endtask

   task automatic t_reset();
      check(done == 1'b0, "R1 done", done, 0);
      check(wtc == '0, "R1 wtc", wtc, 0);
      check(over_limit == 1'b0, "R1 over_limit", over_limit, 0);
   endtask

   task automatic t_alternate();
      push_vec(16'hAAAA, 1'b0, 0, 1'b1, 1'b0, 127, "R3 R8 alternate load");
      idle_check("R3");
      push_vec(16'h5555, 1'b1, 0, 1'b1, 1'b0, 119, "R4 R8 alternate unload");
      idle_check("R4");
   endtask

   task automatic t_single_edge();
      // bits 1..3 zero, 4..16 one: only j=3 toggles
      push_vec(16'hFFF8, 1'b0, 0, 1'b1, 1'b0, 12, "R3 R7 edge j3 load above");
      push_vec(16'hFFF8, 1'b0, 0, 1'b1, 1'b0, 13, "R3 R7 edge j3 load equal");
      push_vec(16'hFFF8, 1'b1, 0, 1'b1, 1'b0, 2,  "R4 R7 edge j3 unload above");
      push_vec(16'hFFF8, 1'b1, 0, 1'b1, 1'b0, 3,  "R4 R7 edge j3 unload equal");
      idle_check("R7");
   endtask

   task automatic t_zero();
      push_vec(16'h0000, 1'b0, 0, 1'b1, 1'b0, 0, "R2 zero load");
      push_vec(16'hFFFF, 1'b1, 0, 1'b1, 1'b0, 0, "R2 ones unload");
      // only bit1 differs from the rest: j=1 toggle, load weight 15
      push_vec(16'h0001, 1'b0, 0, 1'b1, 1'b0, 100, "R2 R3 bit1 lone");
      idle_check("R2");
   endtask

   task automatic t_random();
      for (int k = 0; k < 8; k++) begin
         logic [M-1:0] v;
         v = M'($urandom);
         push_vec(v, k[0], 0, 1'b1, 1'b0, int'($urandom_range(0, 120)),
                  k[0] ? "R4 random unload" : "R3 random load");
      end
      idle_check("R3 R4");
   endtask

   task automatic t_gaps();
      push_vec(16'hC3A5, 1'b0, 2, 1'b1, 1'b0, 60, "R6 gaps load");
      push_vec(16'h3C5A, 1'b1, 3, 1'b1, 1'b0, 60, "R6 gaps unload");
      idle_check("R6");
   endtask

   task automatic t_restart();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         bit_vld = 1'b1; bit_in = i[0]; vec_start = (i == 0); dir_sel = 1'b1;
      end
      push_vec(16'h00F0, 1'b0, 0, 1'b1, 1'b0, 10, "R2 restart on vec_start");
      idle_check("R2");
   endtask

   task automatic t_b2b();
      push_vec(16'h0F0F, 1'b0, 0, 1'b1, 1'b1, 50, "R9 first, dir flipped later");
      push_vec(16'h1234, 1'b1, 0, 1'b0, 1'b1, 50, "R9 back to back no start");
      push_vec(16'hFF00, 1'b0, 0, 1'b0, 1'b1, 50, "R9 third no start");
      idle_check("R9");
   endtask

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_alternate();
      t_single_edge();
      t_zero();
      t_random();
      t_gaps();
      t_restart();
      t_b2b();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule